// File: doc/BRIEF.md
# MII Management Master Controller

This block is the management-bus master that a host processor uses to read and write the registers of an Ethernet PHY. Software loads a PHY address and a register number into an address register. It then either writes the value to send into a write-data register, or sets a read command bit. The block divides the system clock to make the management clock MDC. It then shifts one standard management frame out on the MDIO line and, for a read, shifts the PHY's reply back in.

While a frame is in flight an indicator bit reads 1. Software polls it, and after a read it collects the 16-bit result from the read-data register. A configuration register holds the clock divisor and a bit that holds all management logic in reset. The register interface is a plain single-cycle write strobe with an address and data, plus a combinational read-back bus.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at word addresses 0 (configuration), 1 (command), 2 (address), 3 (write data), 4 (read data) and 5 (indicator). After reset the indicator reads 0, the configuration reads 0x0000001C, the command reads 0, MDC is low and MDIO is not driven.
- R2: The address register holds the PHY address in bits [12:8] and the register number in bits [4:0]. Frame bits 36..40 carry the PHY address and bits 41..45 carry the register number, each most significant bit first.
- R3: Writing the write-data register while idle starts a write frame that carries the low 16 bits of the written value. All 64 bits are driven: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10, then the data MSB first.
- R4: Writing 1 to command bit 0 while idle and while that bit is 0 starts a read frame with opcode 10. MDIO is driven for bits 0..45 only and released from the turnaround (bit 46) onward.
- R5: During a read, MDIO is sampled in the clock cycle in which MDC rises, for each of frame bits 48..63. The 16 sampled bits, first sample as MSB, appear in bits [15:0] of the read-data register when the indicator clears.
- R6: Indicator bit 0 reads 1 from the clock after the starting write for exactly 65 times the effective divisor cycles: 64 frame bits plus one idle MDC period after the last data bit.
- R7: Each MDC period is D − floor(D/2) cycles low followed by floor(D/2) cycles high, where D is the effective divisor. MDC is low and MDIO is undriven whenever the block is idle, and MDIO changes only while MDC is low.
- R8: Configuration bits [7:0] set the divisor, so 0x1C divides by 28. Values below 2 act as 2. The divisor is captured when a frame starts, and a later change does not alter the running frame.
- R9: A command or write-data write that arrives while busy is ignored: the register keeps its value and no further frame starts.
- R10: A write of 1 to command bit 0 while that bit already reads 1 starts nothing. Software must write 0 first.
- R11: Setting configuration bit 15 aborts any frame within two clocks, with the indicator at 0, MDC low and MDIO undriven. While that bit is set, command and write-data writes are ignored. Clearing it lets frames start again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read-back of the addressed register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Reads and writes are both tried with PHY addresses and register numbers of all ones, all zeros and mixed patterns. Write data and PHY replies include 0x0000, 0xFFFF, single-ended values such as 0x8001 and alternating patterns, so a swapped field, a reversed bit order or a frame shifted by one bit shows up as a mismatch. Divisors of 2, 3, 4, 5 and 28, plus the clamped values 0 and 1, separate odd from even high/low splits and exercise the busy length. Directed sequences then issue accesses during a frame, repeat a command without clearing it, change the divisor in mid-frame and apply the management reset in mid-frame, each followed by observing the registers and the pins.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the management bus master.
// Assumes the standard clause-22 frame layout; frame positions are
// derived here so every module agrees on them.
package mdio_pkg;

    localparam int BUS_W    = 32;
    localparam int RA_W     = 3;
    localparam int DATA_W   = 16;
    localparam int PHYA_W   = 5;
    localparam int REGA_W   = 5;
    localparam int PRE_LEN  = 32;

    // Frame layout: preamble, start, opcode, addresses, turnaround, data
    localparam int TA_POS    = PRE_LEN + 4 + PHYA_W + REGA_W;
    localparam int DATA_POS  = TA_POS + 2;
    localparam int FRAME_LEN = DATA_POS + DATA_W;

    // Register field positions
    localparam int PHY_LSB     = 8;
    localparam int REG_LSB     = 0;
    localparam int CFG_RST_BIT = 15;

    // Register word addresses
    localparam logic [RA_W-1:0] RA_CFG   = 3'd0;
    localparam logic [RA_W-1:0] RA_CMD   = 3'd1;
    localparam logic [RA_W-1:0] RA_ADDR  = 3'd2;
    localparam logic [RA_W-1:0] RA_WDATA = 3'd3;
    localparam logic [RA_W-1:0] RA_RDATA = 3'd4;
    localparam logic [RA_W-1:0] RA_IND   = 3'd5;

    // Frame codes
    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] TA_WR    = 2'b10;
    localparam logic [1:0] TA_RD    = 2'b11;

    // One transaction request handed from the register file to the shifter
    typedef struct packed {
        logic              is_read;
        logic [PHYA_W-1:0] phy;
        logic [REGA_W-1:0] regad;
        logic [DATA_W-1:0] data;
    } mdio_req_t;

endpackage

// File: rtl/mdio_regs.sv
// Module: register file and start decode.
// Holds configuration, command, address, write-data and read-data
// registers and generates a one-cycle start pulse with a request.
// Assumes one write per cycle on a strobe and combinational read-back.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wen,
    input  logic [RA_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             busy,
    input  logic [DATA_W-1:0] rd_result,
    input  logic             rd_done,
    output logic             start,
    output mdio_req_t        req,
    output logic [DIV_W-1:0] div_val,
    output logic             mgmt_rst
);

    logic              cfg_rst_q;
    logic [DIV_W-1:0]  cfg_div_q;
    logic              cmd_q;
    logic [PHYA_W-1:0] phy_q;
    logic [REGA_W-1:0] reg_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;

    logic accept;
    logic wr_cfg, wr_cmd, wr_addr, wr_wd;
    logic start_rd, start_wr;

    // Decode of the write strobe per register
    always_comb begin
        wr_cfg  = bus_wen && (bus_addr == RA_CFG);
        wr_cmd  = bus_wen && (bus_addr == RA_CMD);
        wr_addr = bus_wen && (bus_addr == RA_ADDR);
        wr_wd   = bus_wen && (bus_addr == RA_WDATA);
    end

    // Start conditions: idle, not held in management reset
    always_comb begin
        accept   = !busy && !cfg_rst_q;
        start_rd = accept && wr_cmd && bus_wdata[0] && !cmd_q;
        start_wr = accept && wr_wd;
        start    = start_rd || start_wr;
    end

    // Request presented to the shifter alongside the start pulse
    always_comb begin
        req.is_read = start_rd;
        req.phy     = phy_q;
        req.regad   = reg_q;
        req.data    = bus_wdata[DATA_W-1:0];
    end

    // Configuration register: always writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rst_q <= 1'b0;
            cfg_div_q <= DIV_W'(DEF_DIV);
        end else if (wr_cfg) begin
            cfg_rst_q <= bus_wdata[CFG_RST_BIT];
            cfg_div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // Command and write-data registers: only accepted while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 1'b0;
            wdat_q <= '0;
        end else begin
            if (wr_cmd && accept) cmd_q  <= bus_wdata[0];
            if (wr_wd && accept)  wdat_q <= bus_wdata[DATA_W-1:0];
        end
    end

    // Address register: always writable, frame latches its own copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
        end else if (wr_addr) begin
            phy_q <= bus_wdata[PHY_LSB +: PHYA_W];
            reg_q <= bus_wdata[REG_LSB +: REGA_W];
        end
    end

    // Read-data register: loaded when a read frame completes
    always_ff @(posedge clk) begin
        if (!rst_n) rdat_q <= '0;
        else if (rd_done) rdat_q <= rd_result;
    end

    // Read-back multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CFG: begin
                bus_rdata[DIV_W-1:0]  = cfg_div_q;
                bus_rdata[CFG_RST_BIT] = cfg_rst_q;
            end
            RA_CMD:   bus_rdata[0] = cmd_q;
            RA_ADDR: begin
                bus_rdata[PHY_LSB +: PHYA_W] = phy_q;
                bus_rdata[REG_LSB +: REGA_W] = reg_q;
            end
            RA_WDATA: bus_rdata[DATA_W-1:0] = wdat_q;
            RA_RDATA: bus_rdata[DATA_W-1:0] = rdat_q;
            RA_IND:   bus_rdata[0] = busy;
            default:  bus_rdata = '0;
        endcase
    end

    assign div_val  = cfg_div_q;
    assign mgmt_rst = cfg_rst_q;

    wire unused_wdata = ^{bus_wdata[BUS_W-1:CFG_RST_BIT+1],
                          bus_wdata[CFG_RST_BIT-1:DIV_W]};

endmodule

// File: rtl/mdio_clkgen.sv
// Module: MDC generator.
// Counts system clocks within one bit period, captures the divisor at
// frame start (values below 2 act as 2), and flags the last cycle of a
// period and the cycle in which MDC rises. MDC is low while not running.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             mdc,
    output logic             bit_end,
    output logic             rise
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] div_eff;

    // Clamp of the requested divisor and length of the low phase
    always_comb begin
        div_eff = (div_in < DIV_W'(2)) ? DIV_W'(2) : div_in;
        lo_len  = div_q - (div_q >> 1);
    end

    // Period markers and the clock itself, all from registered state
    always_comb begin
        bit_end = run && (cnt_q == div_q - DIV_W'(1));
        rise    = run && (cnt_q == lo_len - DIV_W'(1));
        mdc     = run && (cnt_q >= lo_len);
    end

    // Divisor capture and the in-period counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= DIV_W'(2);
            cnt_q <= '0;
        end else if (start) begin
            div_q <= div_eff;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= bit_end ? '0 : cnt_q + DIV_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/mdio_frame.sv
// Module: frame shifter.
// Builds the 64-bit management frame at start, steps one bit per MDC
// period, drives or releases MDIO per bit, captures read data on MDC
// rising cycles and holds busy for one idle period after the last bit.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              bit_end,
    input  logic              rise,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_result,
    output logic              rd_done
);

    localparam int BIDX_W = $clog2(FRAME_LEN + 1);
    localparam int POS_W  = $clog2(FRAME_LEN);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(FRAME_LEN);
    localparam logic [BIDX_W-1:0] TA_IDX   = BIDX_W'(TA_POS);
    localparam logic [BIDX_W-1:0] DATA_IDX = BIDX_W'(DATA_POS);

    logic [FRAME_LEN-1:0] frame_q;
    logic [BIDX_W-1:0]    bidx_q;
    logic                 is_rd_q;
    logic [DATA_W-1:0]    sh_q;
    logic                 in_frame;
    logic                 capture;
    logic [POS_W-1:0]     pos;

    // Assemble the frame image for a request
    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_req_t r);
        build_frame = {{PRE_LEN{1'b1}}, SOF_CODE,
                       r.is_read ? OP_RD : OP_WR,
                       r.phy, r.regad,
                       r.is_read ? TA_RD : TA_WR,
                       r.is_read ? {DATA_W{1'b0}} : r.data};
    endfunction

    // Bit-position decode and output drive
    always_comb begin
        in_frame = busy && (bidx_q < LAST_IDX);
        pos      = POS_W'(FRAME_LEN - 1) - bidx_q[POS_W-1:0];
        mdio_o   = in_frame && frame_q[pos];
        mdio_oe  = in_frame && (!is_rd_q || (bidx_q < TA_IDX));
        capture  = in_frame && is_rd_q && rise && (bidx_q >= DATA_IDX);
        rd_done  = busy && bit_end && is_rd_q && (bidx_q == LAST_IDX);
    end

    // Frame sequencing and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy    <= 1'b0;
            bidx_q  <= '0;
            is_rd_q <= 1'b0;
            frame_q <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bidx_q  <= '0;
            is_rd_q <= req.is_read;
            frame_q <= build_frame(req);
        end else if (busy && bit_end) begin
            if (bidx_q == LAST_IDX) begin
                busy   <= 1'b0;
                bidx_q <= '0;
            end else begin
                bidx_q <= bidx_q + BIDX_W'(1);
            end
        end
    end

    // Read-data shift register, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh_q <= '0;
        else if (capture)  sh_q <= {sh_q[DATA_W-2:0], mdio_i};
    end

    assign rd_result = sh_q;

endmodule

// File: rtl/mdio_master.sv
// Module: management bus master top.
// Ties the register file, the MDC generator and the frame shifter
// together. Assumes an external tri-state pad built from mdio_o/mdio_oe.
// DIV_W must stay below the management-reset bit position (15).
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wen,
    input  logic [RA_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);

    logic              busy;
    logic              start;
    mdio_req_t         req;
    logic [DIV_W-1:0]  div_val;
    logic              mgmt_rst;
    logic              bit_end;
    logic              rise;
    logic [DATA_W-1:0] rd_result;
    logic              rd_done;

    mdio_regs #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rd_result (rd_result),
        .rd_done   (rd_done),
        .start     (start),
        .req       (req),
        .div_val   (div_val),
        .mgmt_rst  (mgmt_rst)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mgmt_rst),
        .start   (start),
        .run     (busy),
        .div_in  (div_val),
        .mdc     (mdc),
        .bit_end (bit_end),
        .rise    (rise)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (mgmt_rst),
        .start     (start),
        .req       (req),
        .bit_end   (bit_end),
        .rise      (rise),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_result (rd_result),
        .rd_done   (rd_done)
    );

endmodule

// File: rtl/mdio_master_chk.sv
// Module: property checker bound to the management bus master.
// Watches pins, bus writes, the busy flag and the write-data register.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [RA_W-1:0]   bus_addr,
    input logic              busy,
    input logic              mgmt_rst,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] wdat
);

    // R7: idle means a quiet bus
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7: MDIO only moves while MDC is low
    p_mdio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R3: an idle write-data access launches a frame
    p_write_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == RA_WDATA && !busy && !mgmt_rst) |=> busy);

    // R9: write-data access during a frame leaves the register alone
    p_ignore_wdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == RA_WDATA && busy) |=> $stable(wdat));

    // R11: management reset ends any frame
    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rst |=> !busy);

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .busy     (busy),
    .mgmt_rst (mgmt_rst),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .wdat     (u_regs.wdat_q)
);

// File: tb/mdio_master_tb.sv
// Bench: vector table of transactions, then directed corner cases.
module mdio_master_tb;
    import mdio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [2:0]  bus_addr = RA_IND;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;

    logic rec_o  [0:64];
    logic rec_oe [0:64];

    always #4 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // {is_read, phy, reg, data-or-reply, divisor}
    localparam logic [34:0] VEC [7] = '{
        {1'b0, 5'h01, 5'h00, 16'hA5C3, 8'd4},
        {1'b1, 5'h1F, 5'h1F, 16'h8001, 8'd5},
        {1'b0, 5'h10, 5'h15, 16'hFFFF, 8'd2},
        {1'b1, 5'h00, 5'h02, 16'h1234, 8'd3},
        {1'b0, 5'h0A, 5'h0B, 16'h0000, 8'd0},
        {1'b1, 5'h15, 5'h0A, 16'hFFFF, 8'd28},
        {1'b1, 5'h03, 5'h01, 16'h5A96, 8'd1}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = RA_IND;
        #1;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = RA_IND;
        #1;
    endtask

    task automatic wait_idle();
        bus_addr = RA_IND;
        #1;
        while (bus_rdata[0]) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_xfer(input logic [34:0] v);
        logic        rd;
        logic [4:0]  phy, rg;
        logic [15:0] dat;
        logic [7:0]  dv;
        int          deff, cnt, hcnt, mism, drv;
        logic [63:0] exp;
        logic [9:0]  afield;
        logic [31:0] r;
        {rd, phy, rg, dat, dv} = v;
        deff = (dv < 2) ? 2 : int'(dv);
        bus_write(RA_CFG, {24'h0, dv});
        bus_write(RA_ADDR, {19'h0, phy, 3'h0, rg});
        if (rd) bus_write(RA_CMD, 32'h0);
        @(negedge clk);
        bus_wen = 1'b1;
        bus_addr = rd ? RA_CMD : RA_WDATA;
        bus_wdata = rd ? 32'h1 : {16'h0, dat};
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = RA_IND;
        #1;
        cnt = 0; hcnt = 0;
        fork
            begin
                for (int k = 0; k <= 64; k++) begin
                    @(posedge mdc);
                    @(negedge clk);
                    rec_o[k]  = mdio_o;
                    rec_oe[k] = mdio_oe;
                    if (k + 1 >= 48 && k + 1 <= 63) mdio_i = dat[63 - (k + 1)];
                    else mdio_i = 1'b1;
                end
            end
            begin
                while (bus_rdata[0]) begin
                    cnt++;
                    if (mdc) hcnt++;
                    @(negedge clk);
                    #1;
                end
            end
        join
        mdio_i = 1'b1;
        exp = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
               rd ? 2'b11 : 2'b10, rd ? 16'h0 : dat};
        drv = rd ? 46 : 64;
        mism = 0;
        for (int k = 0; k < 64; k++) begin
            if (rec_oe[k] !== (k < drv)) mism++;
            if ((k < drv) && (rec_o[k] !== exp[63 - k])) mism++;
        end
        if (rec_oe[64] !== 1'b0) mism++;
        for (int k = 0; k < 10; k++) afield[9 - k] = rec_o[36 + k];
        check(afield == {phy, rg}, "R2 address fields", {22'h0, afield}, {22'h0, phy, rg});
        check(mism == 0, rd ? "R4 read frame bits" : "R3 write frame bits", mism, 0);
        check(cnt == 65 * deff, "R6 R8 busy length", cnt, 65 * deff);
        check(hcnt == 65 * (deff / 2), "R7 MDC high cycles", hcnt, 65 * (deff / 2));
        if (rd) begin
            bus_read(RA_RDATA, r);
            check(r == {16'h0, dat}, "R5 read data", r, {16'h0, dat});
            bus_write(RA_CMD, 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int bad;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        bus_read(RA_IND, r);  check(r == 0, "R1 indicator", r, 0);
        bus_read(RA_CFG, r);  check(r == 32'h1C, "R1 config", r, 32'h1C);
        bus_read(RA_CMD, r);  check(r == 0, "R1 command", r, 0);
        check(!mdc && !mdio_oe, "R1 pins idle", {mdc, mdio_oe}, 0);

        for (int i = 0; i < 7; i++) run_xfer(VEC[i]);

        // R9: accesses while busy are ignored
        bus_write(RA_CFG, 32'h4);
        bus_write(RA_ADDR, 32'h0102);
        bus_write(RA_WDATA, 32'h1111);
        bus_write(RA_WDATA, 32'h2222);
        bus_write(RA_CMD, 32'h1);
        wait_idle();
        bus_read(RA_WDATA, r); check(r == 32'h1111, "R9 write data kept", r, 32'h1111);
        bus_read(RA_CMD, r);   check(r == 0, "R9 command kept", r, 0);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); #1;
            if (bus_rdata[0] || mdc || mdio_oe) bad++;
        end
        check(bad == 0, "R9 no second frame", bad, 0);

        // R10: command must be cleared before a new read
        bus_write(RA_CMD, 32'h1);
        wait_idle();
        bus_write(RA_CMD, 32'h1);
        @(negedge clk); #1;
        check(bus_rdata[0] == 1'b0, "R10 repeated 1 ignored", bus_rdata[0], 0);
        bus_write(RA_CMD, 32'h0);
        bus_write(RA_CMD, 32'h1);
        check(bus_rdata[0] == 1'b1, "R10 restart after clear", bus_rdata[0], 1);
        wait_idle();
        bus_write(RA_CMD, 32'h0);

        // R8: divisor captured at start
        bus_write(RA_CFG, 32'h4);
        bus_write(RA_WDATA, 32'h00C3);
        bus_write(RA_CFG, 32'hA);
        repeat (257) @(negedge clk);
        #1;
        check(bus_rdata[0] == 1'b1, "R8 busy before end", bus_rdata[0], 1);
        @(negedge clk); #1;
        check(bus_rdata[0] == 1'b0, "R8 busy ends at 65x4", bus_rdata[0], 0);

        // R11: management reset aborts and blocks
        bus_write(RA_CFG, 32'h8);
        bus_write(RA_WDATA, 32'h4444);
        repeat (100) @(negedge clk);
        bus_write(RA_CFG, 32'h8008);
        @(negedge clk); #1;
        check(bus_rdata[0] == 1'b0, "R11 abort indicator", bus_rdata[0], 0);
        check(!mdc && !mdio_oe, "R11 abort pins", {mdc, mdio_oe}, 0);
        bus_write(RA_WDATA, 32'h3333);
        bus_write(RA_CMD, 32'h1);
        @(negedge clk); #1;
        check(bus_rdata[0] == 1'b0 && !mdio_oe, "R11 no start in reset", bus_rdata[0], 0);
        bus_read(RA_WDATA, r); check(r == 32'h4444, "R11 write data kept", r, 32'h4444);
        bus_read(RA_CMD, r);   check(r == 0, "R11 command kept", r, 0);
        bus_write(RA_CFG, 32'h8);
        bus_write(RA_WDATA, 32'h5555);
        check(bus_rdata[0] == 1'b1, "R11 recovery start", bus_rdata[0], 1);
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule